// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital front end that sets a six-bit step attenuator. It turns a mode select, a three-wire serial port (data, clock, latch enable), six parallel control inputs and two boot-select inputs into the attenuation word that drives the switched attenuator array. The word has one bit per binary step, from 16 dB down to 0.5 dB, so it covers 0 to 31.5 dB in half-decibel steps. The all-zero word is the reference-loss state.

All inputs are asynchronous to the fast system clock. Each one passes through a two-flop synchronizer, and serial data is shifted on a detected rising edge of the synchronized serial clock. Latch enable acts as a transparent latch on whichever source the mode picks. When it is high the output follows the source. When it is low the output holds. This single rule gives serial latching, direct parallel control and latched parallel control. Release of the synchronous reset stands in for power-up. On the first clock after release the block loads a start-up word. In serial mode, and in parallel mode with latch enable high, this word comes from the parallel pins. In parallel mode with latch enable low, it comes from a four-entry table indexed by the boot-select pins. A one-cycle strobe marks every change of the output word.

Top module: `step_atten_ctrl`

## Requirements
- R1: `ser_mode_i` low makes the parallel inputs the source. `ser_mode_i` high makes the serial shift register the source.
- R2: Output bit 5 weighs 16 dB, bit 4 weighs 8 dB, bit 3 weighs 4 dB, bit 2 weighs 2 dB, bit 1 weighs 1 dB and bit 0 weighs 0.5 dB. In parallel mode with latch enable held high, `atten_o` equals `par_i` (bit for bit, same positions).
- R3: The shift register moves one place toward bit 5 on each rising edge of `sclk_i` and takes `sdat_i` into bit 0. After six edges, the first bit sent sits in bit 5 (16 dB) and the last bit sent sits in bit 0.
- R4: Shifting happens whatever the level of `le_i`. Bits shifted while `le_i` is low are kept, and they appear at the output once `le_i` goes high.
- R5: In serial mode with `le_i` high, `atten_o` follows the shift register, including each new shift.
- R6: While `le_i` is low after start-up, `atten_o` holds in both modes, whatever the parallel or serial inputs do. A high pulse on `le_i` then a return to low captures the source and keeps it.
- R7: At start-up in serial mode, `atten_o` is loaded from `par_i`.
- R8: At start-up in parallel mode with `le_i` low, `boot_sel_i` selects the word. 00 gives 000000. 01 gives 010000 (8 dB). 10 gives 100000 (16 dB). 11 gives 111110 (31 dB).
- R9: At start-up in parallel mode with `le_i` high, `boot_sel_i` is ignored and `atten_o` equals `par_i`.
- R10: `atten_vld_o` is high for exactly one clock in each cycle in which `atten_o` takes a new value. Rewriting the same value gives no strobe.
- R11: While `rst` is high, `atten_o` is 000000 and `atten_vld_o` is low. The start-up word appears within four clocks of reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; its release models power-up |
| ser_mode_i | input | 1 | 0 = parallel control, 1 = serial control |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdat_i | input | 1 | Serial data, first bit goes to the 16 dB position |
| le_i | input | 1 | Latch enable, high = transparent |
| par_i | input | 6 | Parallel attenuation word |
| boot_sel_i | input | 2 | Start-up table index for parallel mode with latch enable low |
| atten_o | output | 6 | Attenuation word to the switch array |
| atten_vld_o | output | 1 | One-clock strobe on each change of `atten_o` |

## Verification
The hardest situations to reach are the start-up cases, because each one exists only on the single clock after reset release. The bench therefore repeats reset with the mode, latch enable, boot-select and parallel pins set up beforehand and held across release. This covers all four table entries, the case where latch enable high overrides the table, and the serial case. A second hard case is a serial word that sits hidden in the shift register while latch enable is low. The bench checks that the output does not move during the shifting. It then raises latch enable and checks both the bit order and the single strobe.

// File: rtl/atten_pkg.sv
package atten_pkg;

    localparam int ATT_W   = 6;
    localparam int SEL_W   = 2;
    localparam int SYNC_N  = 2;

    typedef logic [ATT_W-1:0] att_word_t;
    typedef logic [SEL_W-1:0] boot_sel_t;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_t;

    // Raw control pins gathered for one synchronizer bank.
    typedef struct packed {
        logic      ser_mode;
        logic      le;
        logic      sclk;
        logic      sdat;
        boot_sel_t boot_sel;
        att_word_t par;
    } ctl_in_t;

    localparam int CTL_W = $bits(ctl_in_t);

    localparam att_word_t W_8DB  = att_word_t'(1) << (ATT_W - 2);
    localparam att_word_t W_16DB = att_word_t'(1) << (ATT_W - 1);
    localparam att_word_t W_31DB = ~att_word_t'(1);

    // Start-up table for parallel mode with latch enable low.
    function automatic att_word_t boot_table(input boot_sel_t sel);
        att_word_t w;
        case (sel)
            2'b01:   w = W_8DB;
            2'b10:   w = W_16DB;
            2'b11:   w = W_31DB;
            default: w = '0;
        endcase
        return w;
    endfunction

    // Start-up word chosen from mode and latch enable.
    function automatic att_word_t boot_word(input logic ser, input logic le,
                                            input boot_sel_t sel,
                                            input att_word_t par);
        att_word_t w;
        if (ser || le) w = par;
        else           w = boot_table(sel);
        return w;
    endfunction

endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) stg[0] <= d;

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) stg[i] <= stg[i-1];
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/atten_shreg.sv
module atten_shreg
    import atten_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  att_word_t load_val,
    input  logic      sclk_s,
    input  logic      sdat_s,
    output att_word_t sreg
);
    logic sclk_d;
    logic rise;

    assign rise = sclk_s & ~sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            sreg   <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (load)      sreg <= load_val;
            else if (rise) sreg <= {sreg[ATT_W-2:0], sdat_s};
        end
    end

    // R3: one place toward the MSB per detected edge, new bit at the LSB
    a_r3_shift_order: assert property (@(posedge clk) disable iff (rst)
        (rise && !load) |=> (sreg == {$past(sreg[ATT_W-2:0]), $past(sdat_s)}));

    // R4: without an edge or load the register keeps its bits
    a_r4_shift_hold: assert property (@(posedge clk) disable iff (rst)
        (!rise && !load) |=> $stable(sreg));
endmodule

// File: rtl/atten_out.sv
module atten_out
    import atten_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ser_s,
    input  logic      le_s,
    input  boot_sel_t sel_s,
    input  att_word_t par_s,
    input  att_word_t sreg,
    output logic      boot,
    output att_word_t atten,
    output logic      vld
);
    ctl_state_t state;
    att_word_t  src;
    att_word_t  nxt;

    assign boot = (state == ST_BOOT);
    assign src  = ser_s ? sreg : par_s;

    always_comb begin
        if (boot)      nxt = boot_word(ser_s, le_s, sel_s, par_s);
        else if (le_s) nxt = src;
        else           nxt = atten;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_BOOT;
            atten <= '0;
            vld   <= 1'b0;
        end else begin
            state <= ST_RUN;
            atten <= nxt;
            vld   <= (nxt != atten);
        end
    end

    // R6: latch closed after start-up holds the word
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!boot && !le_s) |=> $stable(atten));

    // R5: serial transparency
    a_r5_ser_follow: assert property (@(posedge clk) disable iff (rst)
        (!boot && le_s && ser_s) |=> (atten == $past(sreg)));

    // R2: parallel direct mode
    a_r2_par_follow: assert property (@(posedge clk) disable iff (rst)
        (!boot && le_s && !ser_s) |=> (atten == $past(par_s)));

    // R8: start-up table
    a_r8_boot_table: assert property (@(posedge clk) disable iff (rst)
        (boot && !ser_s && !le_s) |=> (atten == boot_table($past(sel_s))));

    // R7 / R9: start-up from the parallel pins
    a_r7_boot_par: assert property (@(posedge clk) disable iff (rst)
        (boot && (ser_s || le_s)) |=> (atten == $past(par_s)));

    // R10: strobe marks a change and nothing else
    a_r10_strobe: assert property (@(posedge clk) disable iff (rst)
        vld == !$stable(atten));

    // R11: reset state
    a_r11_reset: assert property (@(posedge clk)
        $past(rst) |-> (atten == '0 && !vld));
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
    import atten_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_mode_i,
    input  logic       sclk_i,
    input  logic       sdat_i,
    input  logic       le_i,
    input  logic [5:0] par_i,
    input  logic [1:0] boot_sel_i,
    output logic [5:0] atten_o,
    output logic       atten_vld_o
);
    ctl_in_t   raw;
    ctl_in_t   syn;
    logic [CTL_W-1:0] syn_bits;
    att_word_t sreg;
    att_word_t atten;
    logic      boot;
    logic      vld;

    assign raw = '{ser_mode: ser_mode_i, le: le_i, sclk: sclk_i, sdat: sdat_i,
                   boot_sel: boot_sel_i, par: par_i};

    atten_sync #(.W(CTL_W), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .d   (raw),
        .q   (syn_bits)
    );
    assign syn = ctl_in_t'(syn_bits);

    atten_shreg u_shreg (
        .clk      (clk),
        .rst      (rst),
        .load     (boot),
        .load_val (boot_word(syn.ser_mode, syn.le, syn.boot_sel, syn.par)),
        .sclk_s   (syn.sclk),
        .sdat_s   (syn.sdat),
        .sreg     (sreg)
    );

    atten_out u_out (
        .clk   (clk),
        .rst   (rst),
        .ser_s (syn.ser_mode),
        .le_s  (syn.le),
        .sel_s (syn.boot_sel),
        .par_s (syn.par),
        .sreg  (sreg),
        .boot  (boot),
        .atten (atten),
        .vld   (vld)
    );

    assign atten_o     = atten;
    assign atten_vld_o = vld;
endmodule

// File: tb/test_step_atten_ctrl.sv
module test_step_atten_ctrl;
    localparam time CLK = 4ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_mode = 1'b0;
    logic       sclk = 1'b0;
    logic       sdat = 1'b0;
    logic       le = 1'b0;
    logic [5:0] par = '0;
    logic [1:0] bsel = '0;
    logic [5:0] atten;
    logic       vld;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;

    always #(CLK/2) clk = ~clk;

    step_atten_ctrl i_step_atten_ctrl (
        .clk (clk), .rst (rst), .ser_mode_i (ser_mode), .sclk_i (sclk),
        .sdat_i (sdat), .le_i (le), .par_i (par), .boot_sel_i (bsel),
        .atten_o (atten), .atten_vld_o (vld)
    );

    always @(posedge clk) if (!rst && vld) pulses++;

    // Each entry: {par word, expected output} for parallel direct mode (R2)
    localparam logic [11:0] VEC [10] = '{
        {6'b000001, 6'b000001}, {6'b000010, 6'b000010},
        {6'b000100, 6'b000100}, {6'b001000, 6'b001000},
        {6'b010000, 6'b010000}, {6'b100000, 6'b100000},
        {6'b111111, 6'b111111}, {6'b000000, 6'b000000},
        {6'b101010, 6'b101010}, {6'b010101, 6'b010101}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic boot(input logic m, input logic l, input logic [1:0] s, input logic [5:0] p);
        @(negedge clk);
        rst = 1'b1; ser_mode = m; le = l; bsel = s; par = p; sclk = 1'b0;
        tick(4);
        chk("R11 reset word", atten, 6'b0);
        chk("R11 reset strobe", vld, 1'b0);
        rst = 1'b0;
        tick(4);
    endtask

    task automatic sbit(input logic b);
        sdat = b; tick(3);
        sclk = 1'b1; tick(3);
        sclk = 1'b0; tick(3);
    endtask

    initial begin
        #(CLK * 200000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int p0;
        // R8: start-up table, all four entries
        boot(1'b0, 1'b0, 2'b00, 6'b111111); chk("R8 sel 00", atten, 6'b000000);
        boot(1'b0, 1'b0, 2'b01, 6'b111111); chk("R8 sel 01", atten, 6'b010000);
        boot(1'b0, 1'b0, 2'b10, 6'b000000); chk("R8 sel 10", atten, 6'b100000);
        p0 = pulses;
        boot(1'b0, 1'b0, 2'b11, 6'b000000); chk("R8 sel 11", atten, 6'b111110);
        chk("R10 boot strobe", pulses - p0, 1);
        // R9: latch enable high overrides the table
        boot(1'b0, 1'b1, 2'b11, 6'b000101); chk("R9 sel ignored", atten, 6'b000101);
        // R7: serial start-up from parallel pins
        boot(1'b1, 1'b0, 2'b01, 6'b101001); chk("R7 serial boot", atten, 6'b101001);

        // R1/R2: parallel direct mode walk
        boot(1'b0, 1'b1, 2'b00, 6'b000000);
        for (int i = 0; i < 10; i++) begin
            par = VEC[i][11:6];
            tick(5);
            chk("R2 direct", atten, VEC[i][5:0]);
        end

        // R10: same value again gives no strobe
        p0 = pulses;
        par = 6'b010101; tick(5);
        chk("R10 no strobe", pulses - p0, 0);
        par = 6'b010100; tick(5);
        chk("R10 one strobe", pulses - p0, 1);

        // R6: latched parallel
        le = 1'b0; tick(4);
        par = 6'b110011; tick(5);
        chk("R6 par hold", atten, 6'b010100);
        le = 1'b1; tick(4); le = 1'b0; tick(4);
        par = 6'b000111; tick(5);
        chk("R6 par capture", atten, 6'b110011);

        // R1/R3/R4: serial load with latch closed
        ser_mode = 1'b1; tick(4);
        chk("R6 mode change held", atten, 6'b110011);
        sbit(1'b1); sbit(1'b0); sbit(1'b0); sbit(1'b1); sbit(1'b0); sbit(1'b1);
        chk("R4 hidden shift", atten, 6'b110011);
        p0 = pulses;
        le = 1'b1; tick(5);
        chk("R3 msb first", atten, 6'b100101);
        chk("R10 serial strobe", pulses - p0, 1);
        // R5: transparent shifting
        sbit(1'b1);
        chk("R5 follow", atten, 6'b001011);
        le = 1'b0; tick(4);
        sbit(1'b0);
        chk("R6 serial hold", atten, 6'b001011);
        // R1: back to parallel with latch open
        par = 6'b011000; ser_mode = 1'b0; le = 1'b1; tick(5);
        chk("R1 parallel source", atten, 6'b011000);
        ser_mode = 1'b1; tick(5);
        chk("R1 serial source", atten, 6'b010110);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule